// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer

This block holds two 8-bit up-counters, channel 0 and channel 1. Each has its own control register, two compare registers (A and B), sticky flags for both compares, and one output pin. A count-enable strobe from a shared prescaler sets the count rate. A channel counts on that strobe when its clock code says so. An external clear input per channel can reset the counter while it is held high.

The clock code 3'b100 chains the two channels. Placed in channel 0, it forms one 16-bit counter: channel 0 is the high byte and channel 1 is the low byte. Channel 0's flags, clear and pin then follow 16-bit compares, and channel 1's follow low-byte compares. Placed in channel 1, it makes channel 1 count the compare-A events of channel 0. Each channel still keeps its own flags, clear and pin behaviour.

Software reaches all state through a small write/read register bus. Address bit 3 selects the channel and bits 2:0 select the register: 0 control {clear code[4:3], clock code[2:0]}, 1 pin control {B code[3:2], A code[1:0]}, 2 counter, 3 compare A, 4 compare B, 5 flags {B[1], A[0]}. Offsets 6 and 7 read as zero.

Top module: `cascade_timer_pair`

## Requirements
- R1: After a synchronous active-low reset, every register, counter, flag and output pin is 0 and both channels are stopped.
- R2: With clock code 3'b001, a channel's counter steps by one on each cycle in which cnt_en is high. Clock code 3'b000, and any other code except 3'b100, stops it. A step from 8'hFF wraps to 8'h00.
- R3: A compare event A (or B) happens on a step during which the counter equals compare register A (or B). The event sets the flag for that compare. Clear code 2'b01 (or 2'b10) makes the step load 0 instead of counting up on event A (or B). Clear code 2'b11 loads 0 on every cycle in which that channel's ext_clr bit is high.
- R4: Clock code 3'b100 in channel 0 alone gives wide mode. The 16-bit value {channel 0 counter, channel 1 counter} steps when cnt_en is high and channel 1 holds code 3'b001. The low byte carries into the high byte on a wrap from 8'hFF to 8'h00.
- R5: In wide mode, channel 0's flags are set only when all 16 bits equal {channel 0 compare, channel 1 compare}. Channel 1's flags are set when the low byte alone matches.
- R6: In wide mode, channel 0's clear code clears both bytes together. This covers clear on a 16-bit event and clear while ext_clr[0] is high. Channel 1's clear code and ext_clr[1] have no effect.
- R7: In wide mode, pin 0 reacts to 16-bit events and pin 1 reacts to low-byte events.
- R8: Clock code 3'b100 in channel 1 alone gives chain mode. Channel 1 steps once per compare-A event of channel 0, and each channel applies its own flags, clear and pin settings.
- R9: A bus write to a counter overrides a step or clear of that counter in the same cycle. A write to a compare register suppresses that register's compare event in the same cycle; in wide mode, a write to either byte suppresses the 16-bit event.
- R10: When both channels hold code 3'b100, neither counter changes except by a bus write.
- R11: Each pin code means 2'b00 no change, 2'b01 drive 0, 2'b10 drive 1 and 2'b11 toggle. On a cycle with both events, a nonzero A code takes precedence over the B code.
- R12: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R13: bus_rdata returns, combinationally, the register that bus_addr selects, using the map above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address: bit 3 channel, bits 2:0 offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_en | input | 1 | Count-enable strobe from the prescaler |
| ext_clr | input | 2 | External clear, one bit per channel |
| tmo | output | 2 | Compare output pins |
| flag_a | output | 2 | Compare-A flags |
| flag_b | output | 2 | Compare-B flags |

## Verification
Assertions check these behaviours on every cycle:
- A counter write lands.
- Flags stay set until cleared, and an event always leaves its flag set.
- Pins move only on events.
- A 16-bit event always comes with a low-byte event.
- A frozen pair never moves.
- A chained channel 1 moves only on channel 0's compare-A events or a clear.

Only the bench's scenarios show the following:
- The exact counts, and the carry position in wide mode.
- Which clear code wins in wide mode.
- The pin-code precedence.
- The write-over-step priority.

For these, the bench runs directed sequences and a long random mix against its own model.

// File: rtl/ctp_pkg.sv
// Package: shared codes of the cascadable timer pair.
// Assumes: counter width of at least 5 bits so a control byte fits the data bus.
package ctp_pkg;
    localparam logic [2:0] SEL_STOP = 3'b000;
    localparam logic [2:0] SEL_RUN  = 3'b001;
    localparam logic [2:0] SEL_CASC = 3'b100;

    localparam logic [1:0] CLR_NONE = 2'b00;
    localparam logic [1:0] CLR_A    = 2'b01;
    localparam logic [1:0] CLR_B    = 2'b10;
    localparam logic [1:0] CLR_EXT  = 2'b11;

    localparam logic [1:0] PIN_KEEP = 2'b00;
    localparam logic [1:0] PIN_LO   = 2'b01;
    localparam logic [1:0] PIN_HI   = 2'b10;
    localparam logic [1:0] PIN_TGL  = 2'b11;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_PINC = 3'd1;
    localparam logic [2:0] OFS_CNT  = 3'd2;
    localparam logic [2:0] OFS_CMPA = 3'd3;
    localparam logic [2:0] OFS_CMPB = 3'd4;
    localparam logic [2:0] OFS_FLAG = 3'd5;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'd0,
        MODE_WIDE  = 2'd1,
        MODE_CHAIN = 2'd2,
        MODE_FROZE = 2'd3
    } mode_t;
endpackage

// File: rtl/ctp_chan_regs.sv
// Module: register set of one timer channel.
// Holds control, pin control, counter, two compares and two sticky flags.
// Assumes: the caller decodes the channel; a bus write beats a counter update;
// an event beats a clearing flag write.
module ctp_chan_regs
    import ctp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_ofs,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_upd,
    input  logic [W-1:0] cnt_nxt,
    input  logic         set_a,
    input  logic         set_b,
    output logic [2:0]   clk_sel,
    output logic [1:0]   clr_sel,
    output logic [3:0]   pin_ctl,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp_a,
    output logic [W-1:0] cmp_b,
    output logic         flg_a,
    output logic         flg_b,
    output logic         wr_cmp_a,
    output logic         wr_cmp_b
);
    logic wr_ctrl, wr_pinc, wr_cnt, wr_flag;

    // Decode which register the bus write targets.
    always_comb begin
        wr_ctrl  = wr_en && (wr_ofs == OFS_CTRL);
        wr_pinc  = wr_en && (wr_ofs == OFS_PINC);
        wr_cnt   = wr_en && (wr_ofs == OFS_CNT);
        wr_cmp_a = wr_en && (wr_ofs == OFS_CMPA);
        wr_cmp_b = wr_en && (wr_ofs == OFS_CMPB);
        wr_flag  = wr_en && (wr_ofs == OFS_FLAG);
    end

    // Control fields: clock code and clear code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel <= SEL_STOP;
            clr_sel <= CLR_NONE;
        end else if (wr_ctrl) begin
            clk_sel <= wr_data[2:0];
            clr_sel <= wr_data[4:3];
        end
    end

    // Pin control codes for events A and B.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_ctl <= '0;
        else if (wr_pinc) pin_ctl <= wr_data[3:0];
    end

    // Counter: a bus write wins over a step or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (wr_cnt)  cnt <= wr_data;
        else if (cnt_upd) cnt <= cnt_nxt;
    end

    // Compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_a <= '0;
            cmp_b <= '0;
        end else begin
            if (wr_cmp_a) cmp_a <= wr_data;
            if (wr_cmp_b) cmp_b <= wr_data;
        end
    end

    // Sticky flags: a written 0 clears, an event sets and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_a <= 1'b0;
            flg_b <= 1'b0;
        end else begin
            flg_a <= set_a || (flg_a && !(wr_flag && !wr_data[0]));
            flg_b <= set_b || (flg_b && !(wr_flag && !wr_data[1]));
        end
    end
endmodule

// File: rtl/ctp_step_ctrl.sv
// Module: mode decode, compare events and next counter values for both channels.
// Purely combinational. Assumes compare-register write strobes arrive in the
// same cycle as the write so that a written register cannot match.
module ctp_step_ctrl
    import ctp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt0,
    input  logic [W-1:0] cnt1,
    input  logic [W-1:0] a0,
    input  logic [W-1:0] a1,
    input  logic [W-1:0] b0,
    input  logic [W-1:0] b1,
    input  logic [2:0]   sel0,
    input  logic [2:0]   sel1,
    input  logic [1:0]   clr0,
    input  logic [1:0]   clr1,
    input  logic         cnt_en,
    input  logic [1:0]   ext_clr,
    input  logic [1:0]   wa,
    input  logic [1:0]   wb,
    output mode_t        mode,
    output logic [1:0]   upd,
    output logic [W-1:0] nxt0,
    output logic [W-1:0] nxt1,
    output logic [1:0]   ev_a,
    output logic [1:0]   ev_b
);
    localparam int WW = 2 * W;

    logic          tk0, tk1, st0, st1, cl0, cl1;
    logic [WW-1:0] wide_q, wide_n;

    // Pick the pairing from the two clock codes.
    always_comb begin
        if (sel0 == SEL_CASC && sel1 == SEL_CASC) mode = MODE_FROZE;
        else if (sel0 == SEL_CASC)                mode = MODE_WIDE;
        else if (sel1 == SEL_CASC)                mode = MODE_CHAIN;
        else                                      mode = MODE_SPLIT;
    end

    // Events, clears and next counter values for the current mode.
    always_comb begin
        tk0    = cnt_en && (sel0 == SEL_RUN);
        tk1    = cnt_en && (sel1 == SEL_RUN);
        st0    = 1'b0;
        st1    = 1'b0;
        cl0    = 1'b0;
        cl1    = 1'b0;
        ev_a   = '0;
        ev_b   = '0;
        upd    = '0;
        nxt0   = cnt0;
        nxt1   = cnt1;
        wide_q = {cnt0, cnt1};
        wide_n = wide_q;
        case (mode)
            MODE_WIDE: begin
                st1     = tk1;
                ev_a[0] = st1 && (wide_q == {a0, a1}) && !wa[0] && !wa[1];
                ev_b[0] = st1 && (wide_q == {b0, b1}) && !wb[0] && !wb[1];
                ev_a[1] = st1 && (cnt1 == a1) && !wa[1];
                ev_b[1] = st1 && (cnt1 == b1) && !wb[1];
                cl0     = (clr0 == CLR_EXT && ext_clr[0]) ||
                          (clr0 == CLR_A && ev_a[0]) ||
                          (clr0 == CLR_B && ev_b[0]);
                wide_n  = cl0 ? '0 : wide_q + 1'b1;
                upd     = {2{cl0 || st1}};
                {nxt0, nxt1} = wide_n;
            end
            MODE_SPLIT, MODE_CHAIN: begin
                st0     = tk0;
                ev_a[0] = st0 && (cnt0 == a0) && !wa[0];
                ev_b[0] = st0 && (cnt0 == b0) && !wb[0];
                cl0     = (clr0 == CLR_EXT && ext_clr[0]) ||
                          (clr0 == CLR_A && ev_a[0]) ||
                          (clr0 == CLR_B && ev_b[0]);
                nxt0    = cl0 ? '0 : cnt0 + 1'b1;
                upd[0]  = cl0 || st0;
                st1     = (mode == MODE_CHAIN) ? ev_a[0] : tk1;
                ev_a[1] = st1 && (cnt1 == a1) && !wa[1];
                ev_b[1] = st1 && (cnt1 == b1) && !wb[1];
                cl1     = (clr1 == CLR_EXT && ext_clr[1]) ||
                          (clr1 == CLR_A && ev_a[1]) ||
                          (clr1 == CLR_B && ev_b[1]);
                nxt1    = cl1 ? '0 : cnt1 + 1'b1;
                upd[1]  = cl1 || st1;
            end
            default: begin
                upd = '0;
            end
        endcase
    end
endmodule

// File: rtl/ctp_pin_out.sv
// Module: one compare output pin driven by event A and event B codes.
// Assumes: a nonzero A code takes precedence when both events coincide.
module ctp_pin_out
    import ctp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_a,
    input  logic       ev_b,
    input  logic [3:0] pin_ctl,
    output logic       pin
);
    logic [1:0] act;

    // Choose the action code for this cycle.
    always_comb begin
        if (ev_a && pin_ctl[1:0] != PIN_KEEP) act = pin_ctl[1:0];
        else if (ev_b)                        act = pin_ctl[3:2];
        else                                  act = PIN_KEEP;
    end

    // Apply the action to the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else begin
            case (act)
                PIN_LO:  pin <= 1'b0;
                PIN_HI:  pin <= 1'b1;
                PIN_TGL: pin <= ~pin;
                default: pin <= pin;
            endcase
        end
    end
endmodule

// File: rtl/cascade_timer_pair.sv
// Module: top of the cascadable pair of up-counter timers.
// Two channel register sets, shared step control, two output pins and a
// combinational read mux. Assumes W >= 5 so control bytes fit.
module cascade_timer_pair
    import ctp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [3:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         cnt_en,
    input  logic [1:0]   ext_clr,
    output logic [1:0]   tmo,
    output logic [1:0]   flag_a,
    output logic [1:0]   flag_b
);
    localparam int NCH = 2;

    logic [NCH-1:0][2:0]   sel_q;
    logic [NCH-1:0][1:0]   clr_q;
    logic [NCH-1:0][3:0]   pin_q;
    logic [NCH-1:0][W-1:0] cnt_q, cmpa_q, cmpb_q, nxt;
    logic [NCH-1:0]        wa, wb, upd, ev_a, ev_b;
    mode_t                 mode;
    logic                  rd_ch;
    logic [2:0]            ofs;

    assign rd_ch = bus_addr[3];
    assign ofs   = bus_addr[2:0];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ctp_chan_regs #(.W(W)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_we && (rd_ch == 1'(i))),
            .wr_ofs   (ofs),
            .wr_data  (bus_wdata),
            .cnt_upd  (upd[i]),
            .cnt_nxt  (nxt[i]),
            .set_a    (ev_a[i]),
            .set_b    (ev_b[i]),
            .clk_sel  (sel_q[i]),
            .clr_sel  (clr_q[i]),
            .pin_ctl  (pin_q[i]),
            .cnt      (cnt_q[i]),
            .cmp_a    (cmpa_q[i]),
            .cmp_b    (cmpb_q[i]),
            .flg_a    (flag_a[i]),
            .flg_b    (flag_b[i]),
            .wr_cmp_a (wa[i]),
            .wr_cmp_b (wb[i])
        );

        ctp_pin_out u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_a    (ev_a[i]),
            .ev_b    (ev_b[i]),
            .pin_ctl (pin_q[i]),
            .pin     (tmo[i])
        );
    end

    ctp_step_ctrl #(.W(W)) u_step (
        .cnt0    (cnt_q[0]),
        .cnt1    (cnt_q[1]),
        .a0      (cmpa_q[0]),
        .a1      (cmpa_q[1]),
        .b0      (cmpb_q[0]),
        .b1      (cmpb_q[1]),
        .sel0    (sel_q[0]),
        .sel1    (sel_q[1]),
        .clr0    (clr_q[0]),
        .clr1    (clr_q[1]),
        .cnt_en  (cnt_en),
        .ext_clr (ext_clr),
        .wa      (wa),
        .wb      (wb),
        .mode    (mode),
        .upd     (upd),
        .nxt0    (nxt[0]),
        .nxt1    (nxt[1]),
        .ev_a    (ev_a),
        .ev_b    (ev_b)
    );

    // Read mux for the addressed channel register.
    always_comb begin
        bus_rdata = '0;
        case (ofs)
            OFS_CTRL: bus_rdata[4:0] = {clr_q[rd_ch], sel_q[rd_ch]};
            OFS_PINC: bus_rdata[3:0] = pin_q[rd_ch];
            OFS_CNT:  bus_rdata      = cnt_q[rd_ch];
            OFS_CMPA: bus_rdata      = cmpa_q[rd_ch];
            OFS_CMPB: bus_rdata      = cmpb_q[rd_ch];
            OFS_FLAG: bus_rdata[1:0] = {flag_b[rd_ch], flag_a[rd_ch]};
            default:  bus_rdata      = '0;
        endcase
    end
endmodule

// File: rtl/ctp_checker.sv
// Module: property checker bound to the timer pair top.
// Observes ports and the step-control outputs; drives nothing.
module ctp_checker
    import ctp_pkg::*;
#(
    parameter int W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic [3:0]           bus_addr,
    input logic [W-1:0]         bus_wdata,
    input logic [1:0]           ext_clr,
    input logic [1:0][W-1:0]    cnt_q,
    input logic [1:0][1:0]      clr_q,
    input logic [1:0]           flag_a,
    input logic [1:0]           flag_b,
    input logic [1:0]           tmo,
    input logic [1:0]           ev_a,
    input logic [1:0]           ev_b,
    input mode_t                mode
);
    logic wr_cnt0, wr_cnt1, wr_flg0, wr_any_cnt;

    assign wr_cnt0    = bus_we && bus_addr == {1'b0, OFS_CNT};
    assign wr_cnt1    = bus_we && bus_addr == {1'b1, OFS_CNT};
    assign wr_flg0    = bus_we && bus_addr == {1'b0, OFS_FLAG};
    assign wr_any_cnt = wr_cnt0 || wr_cnt1;

    AST_CNT0_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt0 |=> cnt_q[0] == $past(bus_wdata));                         // R9
    AST_CNT1_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt1 |=> cnt_q[1] == $past(bus_wdata));                         // R9
    AST_FLAG_A0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a[0] && !wr_flg0) |=> flag_a[0]);                            // R12
    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_a[0] || ev_b[1]) |=> (flag_a[0] || !$past(ev_a[0])) &&
                                  (flag_b[1] || !$past(ev_b[1])));          // R3
    AST_PIN0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_a[0] && !ev_b[0]) |=> $stable(tmo[0]));                       // R11
    AST_PIN1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_a[1] && !ev_b[1]) |=> $stable(tmo[1]));                       // R11
    AST_WIDE_IMPLIES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIDE && ev_a[0]) |-> ev_a[1]);                       // R5
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FROZE && !wr_any_cnt) |=> $stable(cnt_q));           // R10
    AST_CHAIN_STEP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CHAIN && !ev_a[0] && !wr_cnt1 &&
         !(clr_q[1] == CLR_EXT && ext_clr[1])) |=> $stable(cnt_q[1]));     // R8
endmodule

bind cascade_timer_pair ctp_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ext_clr   (ext_clr),
    .cnt_q     (cnt_q),
    .clr_q     (clr_q),
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .tmo       (tmo),
    .ev_a      (ev_a),
    .ev_b      (ev_b),
    .mode      (mode)
);

// File: tb/cascade_timer_pair_tb.sv
// Bench: directed sequences per requirement plus a seeded random mix,
// all compared every cycle against a behavioural model kept here.
module cascade_timer_pair_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_en = 1'b0;
    logic [1:0] ext_clr = '0;
    logic [1:0] tmo, flag_a, flag_b;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    logic [2:0] m_sel [2];
    logic [1:0] m_clr [2];
    logic [3:0] m_pin [2];
    logic [7:0] m_cnt [2];
    logic [7:0] m_a   [2];
    logic [7:0] m_b   [2];
    logic       m_fa  [2];
    logic       m_fb  [2];
    logic       m_o   [2];

    cascade_timer_pair u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en),
        .ext_clr(ext_clr), .tmo(tmo), .flag_a(flag_a), .flag_b(flag_b)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] model_rd(input logic [3:0] ad);
        int c = int'(ad[3]);
        case (ad[2:0])
            3'd0: return {3'b0, m_clr[c], m_sel[c]};
            3'd1: return {4'b0, m_pin[c]};
            3'd2: return m_cnt[c];
            3'd3: return m_a[c];
            3'd4: return m_b[c];
            3'd5: return {6'b0, m_fb[c], m_fa[c]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic pin_next(input logic cur, input logic ea, input logic eb,
                                      input logic [3:0] pc);
        logic [1:0] act;
        if (ea && pc[1:0] != 2'b00) act = pc[1:0];
        else if (eb)                act = pc[3:2];
        else                        act = 2'b00;
        case (act)
            2'b01: return 1'b0;
            2'b10: return 1'b1;
            2'b11: return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_sel[i] = '0; m_clr[i] = '0; m_pin[i] = '0; m_cnt[i] = '0;
            m_a[i] = '0; m_b[i] = '0; m_fa[i] = 0; m_fb[i] = 0; m_o[i] = 0;
        end
    endtask

    // One cycle: drive at negedge, advance the model, compare after posedge.
    task automatic cyc(input logic we, input logic [3:0] ad, input logic [7:0] wd,
                       input logic en, input logic [1:0] ec);
        logic [1:0] wa, wb, ea, eb;
        logic [7:0] nc [2];
        logic       wide, chain, froze, tk0, tk1, st, cl;
        logic [15:0] w16;
        int         ch;
        @(negedge clk);
        bus_we = we; bus_addr = ad; bus_wdata = wd; cnt_en = en; ext_clr = ec;
        ch = int'(ad[3]);
        wa = '0; wb = '0; ea = '0; eb = '0;
        if (we && ad[2:0] == 3'd3) wa[ch] = 1'b1;
        if (we && ad[2:0] == 3'd4) wb[ch] = 1'b1;
        froze = (m_sel[0] == 3'b100) && (m_sel[1] == 3'b100);
        wide  = (m_sel[0] == 3'b100) && !froze;
        chain = (m_sel[1] == 3'b100) && !froze;
        tk0 = en && m_sel[0] == 3'b001;
        tk1 = en && m_sel[1] == 3'b001;
        nc[0] = m_cnt[0]; nc[1] = m_cnt[1];
        if (wide) begin
            w16 = {m_cnt[0], m_cnt[1]};
            st = tk1;
            ea[0] = st && w16 == {m_a[0], m_a[1]} && wa == 2'b00;
            eb[0] = st && w16 == {m_b[0], m_b[1]} && wb == 2'b00;
            ea[1] = st && m_cnt[1] == m_a[1] && !wa[1];
            eb[1] = st && m_cnt[1] == m_b[1] && !wb[1];
            cl = (m_clr[0] == 2'b11 && ec[0]) || (m_clr[0] == 2'b01 && ea[0]) ||
                 (m_clr[0] == 2'b10 && eb[0]);
            if (cl) w16 = '0; else if (st) w16 = w16 + 16'd1;
            {nc[0], nc[1]} = w16;
        end else if (!froze) begin
            st = tk0;
            ea[0] = st && m_cnt[0] == m_a[0] && !wa[0];
            eb[0] = st && m_cnt[0] == m_b[0] && !wb[0];
            cl = (m_clr[0] == 2'b11 && ec[0]) || (m_clr[0] == 2'b01 && ea[0]) ||
                 (m_clr[0] == 2'b10 && eb[0]);
            if (cl) nc[0] = '0; else if (st) nc[0] = m_cnt[0] + 8'd1;
            st = chain ? ea[0] : tk1;
            ea[1] = st && m_cnt[1] == m_a[1] && !wa[1];
            eb[1] = st && m_cnt[1] == m_b[1] && !wb[1];
            cl = (m_clr[1] == 2'b11 && ec[1]) || (m_clr[1] == 2'b01 && ea[1]) ||
                 (m_clr[1] == 2'b10 && eb[1]);
            if (cl) nc[1] = '0; else if (st) nc[1] = m_cnt[1] + 8'd1;
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            m_o[i]  = pin_next(m_o[i], ea[i], eb[i], m_pin[i]);
            m_fa[i] = ea[i] || (m_fa[i] && !(we && ch == i && ad[2:0] == 3'd5 && !wd[0]));
            m_fb[i] = eb[i] || (m_fb[i] && !(we && ch == i && ad[2:0] == 3'd5 && !wd[1]));
            m_cnt[i] = nc[i];
        end
        if (we) begin
            case (ad[2:0])
                3'd0: begin m_sel[ch] = wd[2:0]; m_clr[ch] = wd[4:3]; end
                3'd1: m_pin[ch] = wd[3:0];
                3'd2: m_cnt[ch] = wd;
                3'd3: m_a[ch] = wd;
                3'd4: m_b[ch] = wd;
                default: ;
            endcase
        end
        check("rdata", bus_rdata, model_rd(ad));
        check("tmo", {6'b0, tmo}, {6'b0, m_o[1], m_o[0]});
        check("flags", {4'b0, flag_b, flag_a}, {4'b0, m_fb[1], m_fb[0], m_fa[1], m_fa[0]});
    endtask

    task automatic wr(input logic [3:0] ad, input logic [7:0] wd);
        cyc(1'b1, ad, wd, 1'b0, 2'b00);
    endtask

    task automatic run(input int n, input logic [3:0] ad);
        for (int k = 0; k < n; k++) cyc(1'b0, ad, 8'h00, 1'b1, 2'b00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 0; cnt_en = 0; ext_clr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        model_reset();
        do_reset();

        // R1: reset state of every address and pin
        cur_req = "R1";
        for (int a = 0; a < 16; a++) cyc(1'b0, 4'(a), 8'h00, 1'b1, 2'b11);

        // R2: plain counting, wrap, stopped code
        cur_req = "R2";
        wr(4'h0, 8'h01); wr(4'h2, 8'hFC);
        wr(4'h8, 8'h02);
        run(8, 4'h2);
        run(3, 4'hA);

        // R3 / R11: compare A clear with toggle, B drives high
        cur_req = "R3";
        wr(4'h3, 8'h04); wr(4'h4, 8'h02); wr(4'h2, 8'h00);
        wr(4'h0, 8'h09);
        cur_req = "R11";
        wr(4'h1, 8'b1011);
        run(14, 4'h2);
        wr(4'h4, 8'h04);
        run(10, 4'h5);
        // R3: external clear code
        cur_req = "R3";
        wr(4'h0, 8'h19);
        cyc(1'b0, 4'h2, 8'h00, 1'b1, 2'b01);
        run(3, 4'h2);

        // R12: clear flags, and a clearing write on a match cycle
        cur_req = "R12";
        wr(4'h0, 8'h01); wr(4'h3, 8'h07); wr(4'h2, 8'h06);
        cyc(1'b1, 4'h5, 8'h00, 1'b1, 2'b00);
        cyc(1'b1, 4'h5, 8'h00, 1'b1, 2'b00);
        cyc(1'b1, 4'h5, 8'h02, 1'b1, 2'b00);

        // R9: compare write blocks match, counter write beats step
        cur_req = "R9";
        wr(4'h2, 8'h07);
        cyc(1'b1, 4'h3, 8'h07, 1'b1, 2'b00);
        cyc(1'b1, 4'h2, 8'h40, 1'b1, 2'b00);
        run(2, 4'h2);

        // R4 / R5 / R7: wide mode with carry and low-byte events
        do_reset();
        cur_req = "R4";
        wr(4'h8, 8'h01); wr(4'hA, 8'hFD); wr(4'h2, 8'h00);
        wr(4'h3, 8'h01); wr(4'hB, 8'h02);
        wr(4'h0, 8'h04);
        run(6, 4'h2);
        cur_req = "R5";
        wr(4'h1, 8'b0011); wr(4'h9, 8'b0011);
        run(8, 4'h5);
        run(250, 4'hD);
        run(12, 4'h5);
        cur_req = "R7";
        run(6, 4'h2);

        // R6: wide clear on 16-bit match and on ext_clr[0]; ch1 clear ignored
        cur_req = "R6";
        wr(4'h8, 8'h09); wr(4'h0, 8'h0C);
        wr(4'h2, 8'h01); wr(4'hA, 8'h00);
        run(6, 4'h2);
        wr(4'h8, 8'h19);
        cyc(1'b0, 4'hA, 8'h00, 1'b1, 2'b10);
        wr(4'h0, 8'h1C);
        cyc(1'b0, 4'hA, 8'h00, 1'b1, 2'b01);
        run(2, 4'h2);

        // R8: chain mode
        do_reset();
        cur_req = "R8";
        wr(4'h3, 8'h02); wr(4'h0, 8'h09);
        wr(4'hB, 8'h02); wr(4'h9, 8'b0011);
        wr(4'h8, 8'h0C);
        run(12, 4'hA);
        run(6, 4'hD);

        // R10: frozen pair
        cur_req = "R10";
        wr(4'h0, 8'h04);
        run(4, 4'h2);
        run(4, 4'hA);
        cyc(1'b0, 4'hA, 8'h00, 1'b1, 2'b11);

        // R13: seeded random mix of writes, reads and strobes
        cur_req = "R13";
        for (int k = 0; k < 4000; k++) begin
            logic       we;
            logic [3:0] ad;
            logic [7:0] wd;
            we = ($urandom % 4) == 0;
            ad = 4'($urandom);
            wd = 8'($urandom);
            if (ad[2:0] == 3'd0) begin
                case ($urandom % 5)
                    0: wd[2:0] = 3'b100;
                    1, 2: wd[2:0] = 3'b001;
                    3: wd[2:0] = 3'b000;
                    default: ;
                endcase
            end
            if (ad[2:0] == 3'd3 || ad[2:0] == 3'd4) wd = 8'($urandom % 12);
            cyc(we, ad, wd, ($urandom % 4) != 0, 2'(($urandom % 8 == 0) ? $urandom : 0));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule